// File: doc/BRIEF.md
# Programmable Architectural Event Counter

This block is one performance-monitoring counter for a processor core. The core's control logic sets up an 8-bit event-select code and an 8-bit unit-mask code. A decoder turns each legal pair into one of seven predefined events. Every clock, per-cycle status inputs from the core decide whether the chosen event happened, and the counter then adds one. The status inputs cover clock state, halt, stop-clock request, thermal throttle, frequency switching, idle state, instruction retirement, VM-exit and branch outcomes.

The counter has a parameterised width, a global enable and a synchronous clear. It also has two sticky flags: one for overflow (wrap) and one for an unusable configuration. A constant 7-bit availability vector tells which events this instance supports. The two cache events have no sources in this block, so by default they are marked unsupported.

There is no data stream in or out of the block. All pins are plain level or pulse control and status signals, so there is no valid/ready handshake and no back-pressure. The retire and branch inputs are one-cycle pulses, and at most one instruction retires per cycle.

Top module: `perf_event_counter`

## Requirements
- R1: The pair (event-select, unit-mask) picks the event as follows: 3CH/00H core cycles, 3CH/01H reference cycles, C0H/00H instructions retired, C4H/00H branches retired, C5H/00H mispredicted branches retired, 2EH/4FH cache references, 2EH/41H cache misses. Any other pair is unrecognised.
- R2: `event_avail` equals the parameter `AVAIL`, which defaults to 7'b1100111. The bit assignment is: bit 0 core cycles, bit 1 instructions retired, bit 2 reference cycles, bit 3 cache references, bit 4 cache misses, bit 5 branches retired, bit 6 mispredicted branches. A set bit means the event is supported.
- R3: Core cycles add one in each enabled cycle that meets both conditions:
  - `clk_running` is high.
  - None of `core_halted`, `stop_clk_req`, `thermal_throttle`, `freq_switching` or `idle_state` is high.
  
  Counting does not depend on which clock frequency is in use.
- R4: Reference cycles add one in each enabled cycle where `ref_tick` is high and none of the five stop conditions in R3 is high.
- R5: Instructions retired add one only on a `retire_valid` pulse with `retire_last_uop` high. Non-final micro-ops and the non-final iterations of a repeated instruction are reported without `retire_last_uop` and do not count.
- R6: A retirement pulse with `retire_fault` high, or in a cycle with `vm_exit` high, does not count.
- R7: Branches retired add one per `branch_retired` pulse. Mispredicted branches add one per `branch_retired` pulse that also has `branch_mispredict` high.
- R8: An unrecognised pair, or a pair whose availability bit is 0, keeps the count frozen. While `cnt_en` is high it also sets `cfg_invalid`, which stays set until a clear.
- R9: While `cnt_en` is low, the count does not change.
- R10: When the count wraps from all ones to zero, `overflow` is set, and it stays set until a clear.
- R11: `cnt_clr` zeroes the count, `overflow` and `cfg_invalid` on the next edge, and takes precedence over any increment.
- R12: After reset the count is zero and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_evsel | input | 8 | Event-select code |
| cfg_umask | input | 8 | Unit-mask code |
| cnt_en | input | 1 | Global counting enable |
| cnt_clr | input | 1 | Synchronous clear of count and flags |
| clk_running | input | 1 | Core clock is running this cycle |
| core_halted | input | 1 | Core is halted |
| stop_clk_req | input | 1 | Stop-clock request asserted |
| thermal_throttle | input | 1 | Thermal throttling active |
| freq_switching | input | 1 | Frequency-switch phase of a performance-state change |
| idle_state | input | 1 | Core is in a non-active idle state |
| ref_tick | input | 1 | Reference-clock tick |
| retire_valid | input | 1 | Retirement pulse |
| retire_last_uop | input | 1 | Pulse is the final micro-op of the instruction |
| retire_fault | input | 1 | Instruction faulted before completion |
| vm_exit | input | 1 | VM-exit cycle |
| branch_retired | input | 1 | A branch retired |
| branch_mispredict | input | 1 | The retired branch was mispredicted |
| event_avail | output | 7 | Supported-event vector |
| count | output | WIDTH | Event count |
| overflow | output | 1 | Sticky wrap flag |
| cfg_invalid | output | 1 | Sticky unusable-configuration flag |

## Verification
A wrong decode or a wrong gate term shows at `count` on the very next edge: the counter either adds a step it should not, or misses one. The fault is visible within one cycle of the stimulus. A lost sticky bit in `overflow` or `cfg_invalid` shows as a flag dropping without a clear in between. With a narrow counter, a wrong wrap shows within a few dozen cycles as a missing `overflow`.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [2:0] {
    EV_CORE   = 3'd0,
    EV_INSTR  = 3'd1,
    EV_REF    = 3'd2,
    EV_CREF   = 3'd3,
    EV_CMISS  = 3'd4,
    EV_BR     = 3'd5,
    EV_BRMISS = 3'd6,
    EV_NONE   = 3'd7
  } ev_e;

  localparam int NUM_EV = 7;

  typedef struct packed {
    logic clk_run;
    logic halted;
    logic stop_clk;
    logic throttle;
    logic freq_sw;
    logic idle;
    logic ref_tick;
    logic ret_vld;
    logic ret_last;
    logic ret_fault;
    logic vmexit;
    logic br_ret;
    logic br_miss;
  } stat_t;
endpackage

// File: rtl/pec_decode.sv
module pec_decode
  import pec_pkg::*;
#(
  parameter logic [NUM_EV-1:0] AVAIL = 7'b1100111
) (
  input  logic [7:0] evsel,
  input  logic [7:0] umask,
  output ev_e        ev,
  output logic       bad
);
  logic [NUM_EV:0] avail_ext;
  assign avail_ext = {1'b0, AVAIL};

  always_comb begin
    unique case ({evsel, umask})
      16'h3C00: ev = EV_CORE;
      16'h3C01: ev = EV_REF;
      16'hC000: ev = EV_INSTR;
      16'h2E4F: ev = EV_CREF;
      16'h2E41: ev = EV_CMISS;
      16'hC400: ev = EV_BR;
      16'hC500: ev = EV_BRMISS;
      default:  ev = EV_NONE;
    endcase
  end

  assign bad = !avail_ext[ev];
endmodule

// File: rtl/pec_gate.sv
module pec_gate
  import pec_pkg::*;
(
  input  ev_e   ev,
  input  stat_t st,
  output logic  hit
);
  logic          unhalted;
  logic [NUM_EV:0] hits;

  assign unhalted = !(st.halted || st.stop_clk || st.throttle || st.freq_sw || st.idle);

  always_comb begin
    hits            = '0;
    hits[EV_CORE]   = st.clk_run && unhalted;
    hits[EV_REF]    = st.ref_tick && unhalted;
    hits[EV_INSTR]  = st.ret_vld && st.ret_last && !st.ret_fault && !st.vmexit;
    hits[EV_CREF]   = 1'b0;
    hits[EV_CMISS]  = 1'b0;
    hits[EV_BR]     = st.br_ret;
    hits[EV_BRMISS] = st.br_ret && st.br_miss;
  end

  assign hit = hits[ev];
endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             flag_bad,
  output logic [WIDTH-1:0] count,
  output logic             ovf,
  output logic             invalid
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      ovf     <= 1'b0;
      invalid <= 1'b0;
    end else if (clr) begin
      count   <= '0;
      ovf     <= 1'b0;
      invalid <= 1'b0;
    end else begin
      if (step) begin
        count <= count + WIDTH'(1);
        if (count == ALL_ONES) ovf <= 1'b1;
      end
      if (flag_bad) invalid <= 1'b1;
    end
  end

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !ovf && !invalid);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr |=> ovf);
  p_inv_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid && !clr |=> invalid);
  p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count)) || (count == $past(count) + WIDTH'(1)));
  p_wrap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && (count == ALL_ONES) |=> (count == '0) |-> ovf);
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int                WIDTH = 48,
  parameter logic [NUM_EV-1:0] AVAIL = 7'b1100111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_evsel,
  input  logic [7:0]        cfg_umask,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              clk_running,
  input  logic              core_halted,
  input  logic              stop_clk_req,
  input  logic              thermal_throttle,
  input  logic              freq_switching,
  input  logic              idle_state,
  input  logic              ref_tick,
  input  logic              retire_valid,
  input  logic              retire_last_uop,
  input  logic              retire_fault,
  input  logic              vm_exit,
  input  logic              branch_retired,
  input  logic              branch_mispredict,
  output logic [NUM_EV-1:0] event_avail,
  output logic [WIDTH-1:0]  count,
  output logic              overflow,
  output logic              cfg_invalid
);
  ev_e   ev;
  logic  bad;
  logic  hit;
  stat_t st;

  assign st = '{clk_run:   clk_running,
                halted:    core_halted,
                stop_clk:  stop_clk_req,
                throttle:  thermal_throttle,
                freq_sw:   freq_switching,
                idle:      idle_state,
                ref_tick:  ref_tick,
                ret_vld:   retire_valid,
                ret_last:  retire_last_uop,
                ret_fault: retire_fault,
                vmexit:    vm_exit,
                br_ret:    branch_retired,
                br_miss:   branch_mispredict};

  assign event_avail = AVAIL;

  pec_decode #(.AVAIL(AVAIL)) u_decode (
    .evsel (cfg_evsel),
    .umask (cfg_umask),
    .ev    (ev),
    .bad   (bad)
  );

  pec_gate u_gate (
    .ev  (ev),
    .st  (st),
    .hit (hit)
  );

  pec_accum #(.WIDTH(WIDTH)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .step     (cnt_en && !bad && hit),
    .flag_bad (cnt_en && bad),
    .count    (count),
    .ovf      (overflow),
    .invalid  (cfg_invalid)
  );

  p_core_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CORE) && !cnt_clr &&
    (core_halted || stop_clk_req || thermal_throttle || freq_switching || idle_state)
    |=> $stable(count));
  p_instr_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_INSTR) && !cnt_clr && (vm_exit || retire_fault) |=> $stable(count));
  p_instr_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_INSTR) && !cnt_clr && !retire_last_uop |=> $stable(count));
  p_bad_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad && !cnt_clr |=> $stable(count));
  p_bad_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad && cnt_en && !cnt_clr |=> cfg_invalid);
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !cnt_clr |=> $stable(count));
endmodule

// File: tb/perf_event_counter_tb.sv
module perf_event_counter_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] evsel = 8'h00, umask = 8'h00;
  logic en = 1'b0, clr = 1'b0;
  logic [12:0] v = '0;
  logic [6:0] avail;
  logic [W-1:0] cnt;
  logic ovf, inv;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_ovf = 1'b0, m_inv = 1'b0;

  always #4 clk = ~clk;

  perf_event_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_evsel(evsel), .cfg_umask(umask),
    .cnt_en(en), .cnt_clr(clr),
    .clk_running(v[0]), .core_halted(v[1]), .stop_clk_req(v[2]),
    .thermal_throttle(v[3]), .freq_switching(v[4]), .idle_state(v[5]),
    .ref_tick(v[6]), .retire_valid(v[7]), .retire_last_uop(v[8]),
    .retire_fault(v[9]), .vm_exit(v[10]), .branch_retired(v[11]),
    .branch_mispredict(v[12]),
    .event_avail(avail), .count(cnt), .overflow(ovf), .cfg_invalid(inv)
  );

  // 0 core, 1 instr, 2 ref, 3 cache ref, 4 cache miss, 5 br, 6 br miss, 7 none (R1)
  function automatic int ev_of(input logic [7:0] s, input logic [7:0] u);
    case ({s, u})
      16'h3C00: return 0;
      16'h3C01: return 2;
      16'hC000: return 1;
      16'h2E4F: return 3;
      16'h2E41: return 4;
      16'hC400: return 5;
      16'hC500: return 6;
      default:  return 7;
    endcase
  endfunction

  function automatic logic hit_of(input int e, input logic [12:0] x);
    logic run;
    run = !(|x[5:1]);
    case (e)
      0: return x[0] && run;
      2: return x[6] && run;
      1: return x[7] && x[8] && !x[9] && !x[10];
      5: return x[11];
      6: return x[11] && x[12];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already set at negedge; model, clock, compare
  task automatic cyc(input string tag);
    int e;
    logic good;
    e = ev_of(evsel, umask);
    good = (e != 7) && (e != 3) && (e != 4);
    if (clr) begin
      m_cnt = '0; m_ovf = 1'b0; m_inv = 1'b0;
    end else if (en) begin
      if (!good) m_inv = 1'b1;
      else if (hit_of(e, v)) begin
        if (m_cnt == '1) m_ovf = 1'b1;
        m_cnt = m_cnt + 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " count"}, 32'(cnt), 32'(m_cnt));
    check({tag, " overflow R10"}, 32'(ovf), 32'(m_ovf));
    check({tag, " cfg_invalid R8"}, 32'(inv), 32'(m_inv));
  endtask

  task automatic sweep(input logic [7:0] s, input logic [7:0] u, input string tag,
                       input bit with_en);
    evsel = s; umask = u;
    for (int i = 0; i < (with_en ? 16384 : 8192); i++) begin
      v  = i[12:0];
      en = with_en ? i[13] : 1'b1;
      cyc(with_en ? {tag, "/R9"} : tag);
    end
    en = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset count", 32'(cnt), 0);
    check("R12 reset overflow", 32'(ovf), 0);
    check("R12 reset cfg_invalid", 32'(inv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 event_avail", 32'(avail), 32'h67);

    sweep(8'h3C, 8'h00, "R3 core", 1'b1);
    sweep(8'h3C, 8'h01, "R4 ref", 1'b0);
    sweep(8'hC0, 8'h00, "R5 R6 instr", 1'b0);
    sweep(8'hC4, 8'h00, "R7 br", 1'b0);
    sweep(8'hC5, 8'h00, "R7 brmiss", 1'b0);

    // R5: repeated instruction reported as 5 non-final pulses then one final
    clr = 1'b1; cyc("R11 clear"); clr = 1'b0;
    evsel = 8'hC0; umask = 8'h00;
    for (int k = 0; k < 6; k++) begin
      v = '0; v[7] = 1'b1; v[8] = (k == 5);
      cyc("R5 rep");
    end
    check("R5 rep counted once", 32'(cnt), 1);

    // R11: clear wins over a simultaneous increment
    v = '0; v[7] = 1'b1; v[8] = 1'b1; clr = 1'b1;
    cyc("R11 clear precedence");
    clr = 1'b0;
    check("R11 cleared", 32'(cnt), 0);

    // R1 R8: every select/mask pair with all event inputs active
    v = 13'b1_1001_1100_0001;
    for (int p = 0; p < 65536; p++) begin
      evsel = p[15:8]; umask = p[7:0];
      clr = (p[7:0] == 8'hFF);
      cyc("R1 R8 pair");
    end
    clr = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule